// File: doc/BRIEF.md
# Float-to-Integer Truncating Converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer of `INT_W` bits, which is 32 or 64. The operand arrives as four fields: a class code, a sign, a signed unbiased exponent and a 64-bit significand whose leading 1 is explicit. The conversion always truncates toward zero. The block has no rounding-mode input, so a mode set elsewhere has no effect on it.

Two flags come with each result. The inexact flag reports that fraction bits were dropped. The invalid flag reports that the result could not be represented, either because the operand is too large or because it is infinite or NaN. In that case the output saturates to the most positive integer plus the sign bit, and the inexact flag is forced low.

The result is registered behind a valid strobe, so it appears one cycle after the operand.

Top module: `ftoi_trunc`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_int`, `out_inexact` and `out_invalid` are all 0.
- R2: `out_valid` equals `in_valid` of the previous cycle. In a cycle after `in_valid` was low, `out_int` and both flags keep their previous values.
- R3: The class code is 0 = zero, 1 = number, 2 = infinity, 3 = NaN. A zero-class operand gives `out_int` = 0 with both flags clear, whatever its sign, exponent and significand.
- R4: The value of a number is `in_sig` × 2^(`in_exp` − 63), with the binary point just below bit 63. If the result is in range, `out_int` is the truncated magnitude `in_sig >> (63 − in_exp)`, negated in two's complement when `in_sign` is 1. A negative exponent gives magnitude 0.
- R5: For a number in range, `out_inexact` is 1 exactly when a nonzero significand bit falls below the integer LSB. This includes any nonzero significand with a negative exponent. `out_invalid` is 0 in that case.
- R6: A number with `in_exp` ≥ `INT_W` is an overflow.
- R7: A truncated magnitude of at least 2^(INT_W−1) + `in_sign` is an overflow. So −2^(INT_W−1) is a valid result, but +2^(INT_W−1) is not.
- R8: Infinity and NaN operands are treated as overflow, whatever their sign.
- R9: On overflow, `out_invalid` is 1, `out_inexact` is 0, and `out_int` is 2^(INT_W−1) − 1 + `in_sign`. For INT_W = 32 that is 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one. The two flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_class | input | 2 | Operand class (0 zero, 1 number, 2 infinity, 3 NaN) |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_sig | input | SIG_W | Significand, leading 1 at the top bit |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | INT_W | Truncated two's-complement integer |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Overflow, infinity or NaN |

## Verification
The datapath has one register stage and no other state. A wrong shift amount, a wrong overflow limit or a wrong choice of saturation value therefore shows at `out_int` or on the flags in the very cycle after the operand is strobed.

The sweep covers every exponent from below zero to past the significand width, with both signs and several significand patterns. Because of that, an off-by-one in the alignment or in the asymmetric limit at ±2^(INT_W−1) produces a mismatch within a few operands. A register that fails to hold while `in_valid` is low shows up in the idle cycle that follows every operand.

// File: rtl/ftoi_pkg.sv
package ftoi_pkg;

  typedef enum logic [1:0] {
    FC_ZERO = 2'd0,
    FC_NUM  = 2'd1,
    FC_INF  = 2'd2,
    FC_NAN  = 2'd3
  } fclass_t;

endpackage

// File: rtl/ftoi_align.sv
// Moves the significand so that its binary point sits at the integer LSB.
// It also reports the bits dropped below the LSB and exponents that are out of range.
module ftoi_align #(
  parameter int SIG_W = 64,
  parameter int INT_W = 32,
  parameter int EXP_W = 12
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [EXP_W-1:0] exp,
  output logic [INT_W-1:0] mag,
  output logic             lost,
  output logic             exp_big
);

  localparam int SH_W = $clog2(SIG_W) + 1;
  localparam logic [EXP_W-1:0] LIMIT_E = EXP_W'(INT_W);
  localparam logic [SH_W-1:0]  TOP_POS = SH_W'(SIG_W - 1);

  // Right-shift distance for an exponent known to lie in [0, INT_W-1].
  function automatic logic [SH_W-1:0] shift_amt(input logic [EXP_W-1:0] e);
    return TOP_POS - e[SH_W-1:0];
  endfunction

  // Ones in the sh low-order positions.
  function automatic logic [SIG_W-1:0] low_mask(input logic [SH_W-1:0] sh);
    return ~({SIG_W{1'b1}} << sh);
  endfunction

  logic             exp_neg;
  logic [SH_W-1:0]  sh;

  assign exp_neg = exp[EXP_W-1];
  assign exp_big = !exp_neg && (exp >= LIMIT_E);
  assign sh      = shift_amt(exp);

  always_comb begin
    if (exp_neg) begin
      mag  = '0;
      lost = |sig;
    end else if (exp_big) begin
      mag  = '0;
      lost = 1'b0;
    end else begin
      mag  = INT_W'(sig >> sh);
      lost = |(sig & low_mask(sh));
    end
  end

endmodule

// File: rtl/ftoi_range.sv
// Applies the asymmetric magnitude limit and forms the signed result.
module ftoi_range #(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] mag,
  input  logic             sign,
  output logic             ovf,
  output logic [INT_W-1:0] value
);

  function automatic logic over_limit(input logic [INT_W-1:0] m, input logic s);
    logic [INT_W:0] lim;
    lim = ((INT_W+1)'(1) << (INT_W - 1)) + (INT_W+1)'(s);
    return {1'b0, m} >= lim;
  endfunction

  function automatic logic [INT_W-1:0] apply_sign(input logic [INT_W-1:0] m, input logic s);
    return s ? (~m + INT_W'(1)) : m;
  endfunction

  assign ovf   = over_limit(mag, sign);
  assign value = apply_sign(mag, sign);

endmodule

// File: rtl/ftoi_trunc.sv
module ftoi_trunc
  import ftoi_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int SIG_W = 64,
  parameter int EXP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  output logic                    out_valid,
  output logic [INT_W-1:0]        out_int,
  output logic                    out_inexact,
  output logic                    out_invalid
);

  localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};

  function automatic logic [INT_W-1:0] sat_value(input logic s);
    return SAT_POS + INT_W'(s);
  endfunction

  fclass_t          cls;
  logic [INT_W-1:0] mag_w;
  logic             lost_w;
  logic             exp_big_w;
  logic             ovf_w;
  logic [INT_W-1:0] signed_w;
  logic             is_num;
  logic             is_special;
  logic             invalid_d;
  logic             inexact_d;
  logic [INT_W-1:0] result_d;

  assign cls        = fclass_t'(in_class);
  assign is_num     = (cls == FC_NUM);
  assign is_special = (cls == FC_INF) || (cls == FC_NAN);

  ftoi_align #(
    .SIG_W(SIG_W),
    .INT_W(INT_W),
    .EXP_W(EXP_W)
  ) u_align (
    .sig    (in_sig),
    .exp    (in_exp),
    .mag    (mag_w),
    .lost   (lost_w),
    .exp_big(exp_big_w)
  );

  ftoi_range #(
    .INT_W(INT_W)
  ) u_range (
    .mag  (mag_w),
    .sign (in_sign),
    .ovf  (ovf_w),
    .value(signed_w)
  );

  assign invalid_d = is_special || (is_num && (exp_big_w || ovf_w));
  assign inexact_d = is_num && !invalid_d && lost_w;

  always_comb begin
    if (invalid_d)   result_d = sat_value(in_sign);
    else if (is_num) result_d = signed_w;
    else             result_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= result_d;
        out_inexact <= inexact_d;
        out_invalid <= invalid_d;
      end
    end
  end

endmodule

// File: rtl/ftoi_trunc_chk.sv
module ftoi_trunc_chk #(
  parameter int INT_W = 32,
  parameter int EXP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_class,
  input logic             in_sign,
  input logic [EXP_W-1:0] in_exp,
  input logic             out_valid,
  input logic [INT_W-1:0] out_int,
  input logic             out_inexact,
  input logic             out_invalid,
  input logic             ovf_w,
  input logic             lost_w
);

  localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_int) && $stable(out_inexact) && $stable(out_invalid)));
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd0) |=> (out_int == '0 && !out_inexact && !out_invalid));
  p_positive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sign) |=> !out_int[INT_W-1]);
  p_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd1 && !lost_w) |=> !out_inexact);
  p_big_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd1 && !in_exp[EXP_W-1] && in_exp >= EXP_W'(INT_W)) |=> out_invalid);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd1 && ovf_w) |=> (out_invalid && !out_inexact));
  p_special_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class[1]) |=> out_invalid);
  p_sat_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_int == MAX_POS || out_int == MIN_NEG));
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_invalid && out_inexact));

  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (!out_valid && out_int == '0 && !out_inexact && !out_invalid);
    end
  end

endmodule

bind ftoi_trunc ftoi_trunc_chk #(
  .INT_W(INT_W),
  .EXP_W(EXP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_class   (in_class),
  .in_sign    (in_sign),
  .in_exp     (in_exp),
  .out_valid  (out_valid),
  .out_int    (out_int),
  .out_inexact(out_inexact),
  .out_invalid(out_invalid),
  .ovf_w      (ovf_w),
  .lost_w     (lost_w)
);

// File: tb/ftoi_trunc_tb.sv
`timescale 1ns/1ps
module ftoi_trunc_tb;

  localparam int INT_W = 32;
  localparam int SIG_W = 64;
  localparam int EXP_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [1:0]       in_class = 2'd0;
  logic             in_sign = 1'b0;
  logic [EXP_W-1:0] in_exp = '0;
  logic [SIG_W-1:0] in_sig = '0;
  logic             out_valid;
  logic [INT_W-1:0] out_int;
  logic             out_inexact;
  logic             out_invalid;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  ftoi_trunc #(.INT_W(INT_W), .SIG_W(SIG_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .out_valid(out_valid), .out_int(out_int),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  task automatic check(input string req, input logic av, input logic ev,
                       input logic [31:0] ai, input logic [31:0] ei,
                       input logic ax, input logic ex, input logic an, input logic en);
    n_checks++;
    if (av !== ev || ai !== ei || ax !== ex || an !== en) begin
      n_errors++;
      $display("FAIL %s: got valid=%0b int=%08h nx=%0b nv=%0b, expected valid=%0b int=%08h nx=%0b nv=%0b",
               req, av, ai, ax, an, ev, ei, ex, en);
    end
  endtask

  // Sends one operand, checks the result, then checks that an idle cycle holds it.
  task automatic send(input string req, input logic [1:0] c, input logic s,
                      input int e, input logic [63:0] g,
                      input logic [31:0] ei, input logic ex, input logic en);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_sign = s; in_exp = EXP_W'(e); in_sig = g;
    @(negedge clk);
    check(req, out_valid, 1'b1, out_int, ei, out_inexact, ex, out_invalid, en);
    in_valid = 1'b0; in_class = 2'd1; in_sign = ~s; in_exp = '0; in_sig = ~g;
    @(negedge clk);
    check("R2 hold", out_valid, 1'b0, out_int, ei, out_inexact, ex, out_invalid, en);
  endtask

  // Expected result for a number, computed arithmetically.
  task automatic send_num(input logic s, input int e, input logic [63:0] g);
    logic [63:0] m;
    logic        lost;
    logic        over;
    logic [31:0] res;
    string       tag;
    if (e < 0) begin
      m = 64'd0; lost = (g != 64'd0); over = 1'b0;
    end else if (e >= INT_W) begin
      m = 64'd0; lost = 1'b0; over = 1'b1;
    end else begin
      m    = g >> (63 - e);
      lost = ((g << (e + 1)) != 64'd0);
      over = (m >= (64'h8000_0000 + 64'(s)));
    end
    if (over) begin
      res = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      tag = (e >= INT_W) ? "R6 R9" : "R7 R9";
      send(tag, 2'd1, s, e, g, res, 1'b0, 1'b1);
    end else begin
      res = s ? (32'd0 - m[31:0]) : m[31:0];
      tag = lost ? "R5" : "R4";
      send(tag, 2'd1, s, e, g, res, lost, 1'b0);
    end
  endtask

  initial begin
    logic [63:0] pats [6];
    pats[0] = 64'h8000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hC000_0000_0000_0000;
    pats[3] = 64'h8000_0000_8000_0000;
    pats[4] = 64'hA5A5_0F0F_3C3C_9669;
    pats[5] = 64'h8000_0000_0000_0001;

    repeat (3) @(negedge clk);
    check("R1 reset", out_valid, 1'b0, out_int, 32'd0, out_inexact, 1'b0, out_invalid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 zero class ignores the other fields
    send("R3", 2'd0, 1'b1, 40, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 1'b0, 1'b0);
    send("R3", 2'd0, 1'b0, -5, 64'h8000_0000_0000_0000, 32'd0, 1'b0, 1'b0);
    // R8 infinity and NaN saturate by sign
    send("R8", 2'd2, 1'b0, 0, 64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1);
    send("R8", 2'd2, 1'b1, 0, 64'h8000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1);
    send("R8", 2'd3, 1'b0, 3, 64'hC000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1);
    send("R8", 2'd3, 1'b1, 3, 64'hC000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1);
    // R4 truncation toward zero: -2.5 -> -2 inexact, 1.0 -> 1 exact
    send("R4 R5", 2'd1, 1'b1, 1, 64'hA000_0000_0000_0000, 32'hFFFF_FFFE, 1'b1, 1'b0);
    send("R4", 2'd1, 1'b0, 0, 64'h8000_0000_0000_0000, 32'd1, 1'b0, 1'b0);
    // R7 asymmetric limit at exponent 31
    send("R7", 2'd1, 1'b1, 31, 64'h8000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b0);
    send("R7 R9", 2'd1, 1'b0, 31, 64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1);

    for (int p = 0; p < 6; p++) begin
      for (int e = -4; e <= 67; e++) begin
        send_num(1'b0, e, pats[p]);
        send_num(1'b1, e, pats[p]);
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule